// File: doc/BRIEF.md
# Multi-copy prediction value distributor

This block is the second stage of a two-stage value-prediction path in a wide-fetch front end. A single fetch may hold several copies of the same instruction, for example several loop iterations in one trace. Stage one maps each trace slot onto a bank of an interleaved prediction table and settles conflicts between slots. It then registers a bank index, a grant bit, a copy ordinal and a table-type select for every slot. In the next cycle the banks return a valid bit, a last value and a stride. This block maps those bank results back onto the trace slots and registers one predicted value and one valid bit per slot.

Merged copies of one instruction share a single bank access. When the result comes from the last-value table, every copy receives the same value. When the result comes from the stride table, the copies receive an arithmetic sequence. The copy with ordinal k receives last + (k+1)·stride. A slot is delivered invalid if it lost arbitration or if its bank returned no usable result.

Top module: `pred_value_distributor`

## Requirements
- R1: Outputs are registered. A value presented on the inputs appears on the outputs after exactly one rising clock edge. While rst_ni is low, every valid bit and every value is zero.
- R2: Slot s takes its result from bank b, where b is the unsigned number in bits [s*BANK_W +: BANK_W] of slot_bank_i. BANK_W is clog2(N_BANKS).
- R3: A slot whose slot_grant_i bit is 0 is delivered with pred_valid_o low and a zero value.
- R4: When slot_sel_i bit s is 0 (last-value table), slot s receives the bank's last value unchanged, whatever its ordinal. All copies mapped to one bank therefore receive identical values.
- R5: When slot_sel_i bit s is 1 (stride table), slot s receives last + (k+1)*stride, where k is the unsigned ordinal in bits [s*ORD_W +: ORD_W] of slot_ord_i. ORD_W is clog2(N_SLOTS).
- R6: When bank_valid_i is low for a bank, every granted slot mapped to that bank, leader and followers alike, is delivered invalid with a zero value.
- R7: Stride arithmetic wraps modulo 2^VAL_W.
- R8: The table-type select is applied per slot, so last-value and stride results can be delivered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_bank_i | input | N_SLOTS*BANK_W | Bank index per slot |
| slot_grant_i | input | N_SLOTS | Slot won (or shares) a bank access |
| slot_ord_i | input | N_SLOTS*ORD_W | Copy ordinal within a merged group, 0 for the leader |
| slot_sel_i | input | N_SLOTS | 1 = stride table, 0 = last-value table |
| bank_valid_i | input | N_BANKS | Bank result usable |
| bank_last_i | input | N_BANKS*VAL_W | Last value per bank |
| bank_stride_i | input | N_BANKS*VAL_W | Stride per bank |
| pred_value_o | output | N_SLOTS*VAL_W | Predicted value per slot |
| pred_valid_o | output | N_SLOTS | Prediction valid per slot |

## Verification
Random cycles mix slot-to-bank mappings, grants, ordinals, table selects and bank valid bits. This shows that each slot reads its own bank and that the four delivery cases are kept apart. Directed patterns cover the following:
- Four copies sharing one stride bank, with ordinals 0 to 3. Values that come out equal or in the wrong order show an ordinal handling error.
- The same group switched to the last-value table, to confirm that the ordinal is ignored there.
- A stride large enough to wrap.
- A denied slot and an invalid bank, to separate the two invalidation causes.
- A mixed-select cycle.

// File: rtl/pvd_pkg.sv
package pvd_pkg;
  typedef enum logic {
    TBL_LAST   = 1'b0,
    TBL_STRIDE = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/pvd_slot_mux.sv
module pvd_slot_mux #(
  parameter int N_BANKS = 4,
  parameter int VAL_W   = 32,
  localparam int BANK_W = $clog2(N_BANKS)
) (
  input  logic [BANK_W-1:0]        bank_idx_i,
  input  logic [N_BANKS-1:0]       bank_valid_i,
  input  logic [N_BANKS*VAL_W-1:0] bank_last_i,
  input  logic [N_BANKS*VAL_W-1:0] bank_stride_i,
  output logic                     hit_valid_o,
  output logic [VAL_W-1:0]         hit_last_o,
  output logic [VAL_W-1:0]         hit_stride_o
);
  always_comb begin
    hit_valid_o  = 1'b0;
    hit_last_o   = '0;
    hit_stride_o = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (bank_idx_i == BANK_W'(b)) begin
        hit_valid_o  = bank_valid_i[b];
        hit_last_o   = bank_last_i[b*VAL_W +: VAL_W];
        hit_stride_o = bank_stride_i[b*VAL_W +: VAL_W];
      end
    end
  end
endmodule

// File: rtl/pvd_value_gen.sv
module pvd_value_gen
  import pvd_pkg::*;
#(
  parameter int VAL_W = 32,
  parameter int ORD_W = 3
) (
  input  tbl_sel_e         sel_i,
  input  logic [ORD_W-1:0] ord_i,
  input  logic [VAL_W-1:0] last_i,
  input  logic [VAL_W-1:0] stride_i,
  output logic [VAL_W-1:0] value_o
);
  logic [VAL_W-1:0] step_mul;
  logic [VAL_W-1:0] offset;

  // ordinal k -> (k+1) strides past the last value; wraps at VAL_W
  assign step_mul = VAL_W'(ord_i) + VAL_W'(1);
  assign offset   = step_mul * stride_i;

  always_comb begin
    if (sel_i == TBL_STRIDE) value_o = last_i + offset;
    else                     value_o = last_i;
  end
endmodule

// File: rtl/pvd_slot_reg.sv
module pvd_slot_reg #(
  parameter int VAL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_d_i,
  input  logic [VAL_W-1:0] value_d_i,
  output logic             valid_q_o,
  output logic [VAL_W-1:0] value_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q_o <= 1'b0;
      value_q_o <= '0;
    end else begin
      valid_q_o <= valid_d_i;
      value_q_o <= valid_d_i ? value_d_i : '0;
    end
  end
endmodule

// File: rtl/pred_value_distributor.sv
module pred_value_distributor
  import pvd_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int N_BANKS = 4,
  parameter int VAL_W   = 32,
  localparam int BANK_W = $clog2(N_BANKS),
  localparam int ORD_W  = $clog2(N_SLOTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_SLOTS*BANK_W-1:0]  slot_bank_i,
  input  logic [N_SLOTS-1:0]         slot_grant_i,
  input  logic [N_SLOTS*ORD_W-1:0]   slot_ord_i,
  input  logic [N_SLOTS-1:0]         slot_sel_i,
  input  logic [N_BANKS-1:0]         bank_valid_i,
  input  logic [N_BANKS*VAL_W-1:0]   bank_last_i,
  input  logic [N_BANKS*VAL_W-1:0]   bank_stride_i,
  output logic [N_SLOTS*VAL_W-1:0]   pred_value_o,
  output logic [N_SLOTS-1:0]         pred_valid_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic             hit_valid;
    logic [VAL_W-1:0] hit_last;
    logic [VAL_W-1:0] hit_stride;
    logic [VAL_W-1:0] gen_value;
    logic             slot_ok;
    tbl_sel_e         sel;

    assign sel = tbl_sel_e'(slot_sel_i[s]);

    pvd_slot_mux #(.N_BANKS(N_BANKS), .VAL_W(VAL_W)) u_mux (
      .bank_idx_i   (slot_bank_i[s*BANK_W +: BANK_W]),
      .bank_valid_i (bank_valid_i),
      .bank_last_i  (bank_last_i),
      .bank_stride_i(bank_stride_i),
      .hit_valid_o  (hit_valid),
      .hit_last_o   (hit_last),
      .hit_stride_o (hit_stride)
    );

    pvd_value_gen #(.VAL_W(VAL_W), .ORD_W(ORD_W)) u_gen (
      .sel_i   (sel),
      .ord_i   (slot_ord_i[s*ORD_W +: ORD_W]),
      .last_i  (hit_last),
      .stride_i(hit_stride),
      .value_o (gen_value)
    );

    assign slot_ok = slot_grant_i[s] & hit_valid;

    pvd_slot_reg #(.VAL_W(VAL_W)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_d_i(slot_ok),
      .value_d_i(gen_value),
      .valid_q_o(pred_valid_o[s]),
      .value_q_o(pred_value_o[s*VAL_W +: VAL_W])
    );

    a_r3_denied_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $past(!slot_grant_i[s])) |->
        (!pred_valid_o[s] && pred_value_o[s*VAL_W +: VAL_W] == '0));

    a_r6_bank_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $past(!bank_valid_i[slot_bank_i[s*BANK_W +: BANK_W]])) |->
        !pred_valid_o[s]);

    a_r4_last_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $past(slot_grant_i[s] && !slot_sel_i[s]
                        && bank_valid_i[slot_bank_i[s*BANK_W +: BANK_W]])) |->
        (pred_valid_o[s] && pred_value_o[s*VAL_W +: VAL_W] ==
          $past(bank_last_i[slot_bank_i[s*BANK_W +: BANK_W]*VAL_W +: VAL_W])));

    a_r5_leader_stride: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $past(slot_grant_i[s] && slot_sel_i[s]
                        && slot_ord_i[s*ORD_W +: ORD_W] == '0
                        && bank_valid_i[slot_bank_i[s*BANK_W +: BANK_W]])) |->
        (pred_value_o[s*VAL_W +: VAL_W] ==
          $past(bank_last_i[slot_bank_i[s*BANK_W +: BANK_W]*VAL_W +: VAL_W]
              + bank_stride_i[slot_bank_i[s*BANK_W +: BANK_W]*VAL_W +: VAL_W])));
  end
endmodule

// File: tb/pred_value_distributor_tb.sv
module pred_value_distributor_tb;
  localparam int N  = 8;
  localparam int NB = 4;
  localparam int W  = 32;
  localparam int BW = $clog2(NB);
  localparam int OW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*BW-1:0] slot_bank  = '0;
  logic [N-1:0]    slot_grant = '0;
  logic [N*OW-1:0] slot_ord   = '0;
  logic [N-1:0]    slot_sel   = '0;
  logic [NB-1:0]   bank_valid = '0;
  logic [NB*W-1:0] bank_last  = '0;
  logic [NB*W-1:0] bank_stride = '0;
  logic [N*W-1:0]  pred_value;
  logic [N-1:0]    pred_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pred_value_distributor #(.N_SLOTS(N), .N_BANKS(NB), .VAL_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .slot_bank_i(slot_bank), .slot_grant_i(slot_grant), .slot_ord_i(slot_ord),
    .slot_sel_i(slot_sel), .bank_valid_i(bank_valid), .bank_last_i(bank_last),
    .bank_stride_i(bank_stride), .pred_value_o(pred_value), .pred_valid_o(pred_valid)
  );

  function automatic int bank_of(int s);
    return int'(slot_bank[s*BW +: BW]);
  endfunction

  function automatic logic [W-1:0] exp_value(int s);
    logic [W-1:0] v;
    int b = bank_of(s);
    if (!slot_grant[s] || !bank_valid[b]) return '0;
    v = bank_last[b*W +: W];
    if (slot_sel[s]) begin
      for (int k = 0; k <= int'(slot_ord[s*OW +: OW]); k++)
        v = v + bank_stride[b*W +: W];
    end
    return v;
  endfunction

  function automatic string tag_of(int s);
    if (!slot_grant[s]) return "R3";
    if (!bank_valid[bank_of(s)]) return "R6";
    if (slot_sel[s]) return "R5";
    return "R4";
  endfunction

  task automatic cmp(string tag, logic exp_v, logic [W-1:0] exp_d, int s);
    checks++;
    if (pred_valid[s] !== exp_v || pred_value[s*W +: W] !== exp_d) begin
      fails++;
      $display("FAIL %s slot %0d: got valid=%0b value=%h, expected valid=%0b value=%h",
               tag, s, pred_valid[s], pred_value[s*W +: W], exp_v, exp_d);
    end
  endtask

  task automatic step_check(string tag);
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < N; s++) begin
      logic ev;
      ev = slot_grant[s] && bank_valid[bank_of(s)];
      cmp(tag == "" ? tag_of(s) : tag, ev, exp_value(s), s);
    end
  endtask

  task automatic set_bank(int b, logic v, logic [W-1:0] last, logic [W-1:0] str);
    bank_valid[b] = v;
    bank_last[b*W +: W] = last;
    bank_stride[b*W +: W] = str;
  endtask

  task automatic set_slot(int s, int b, logic g, int ord, logic sel);
    slot_bank[s*BW +: BW] = BW'(b);
    slot_grant[s] = g;
    slot_ord[s*OW +: OW] = OW'(ord);
    slot_sel[s] = sel;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // drive a busy pattern during reset: outputs must stay zero (R1)
    slot_grant = '1;
    bank_valid = '1;
    bank_last  = {NB{32'h1111_1111}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < N; s++) cmp("R1", 1'b0, '0, s);
    rst_n = 1'b1;
    slot_grant = '0;
    @(negedge clk);

    // R1 latency: new inputs do not show before the next edge
    for (int s = 0; s < N; s++) set_slot(s, s % NB, 1'b1, 0, 1'b0);
    for (int b = 0; b < NB; b++) set_bank(b, 1'b1, W'(32'hA000 + b), W'(b + 1));
    #1;
    for (int s = 0; s < N; s++) cmp("R1", 1'b0, '0, s);
    step_check("R2");

    // R5: four copies on bank 2, ordinals 0..3
    set_bank(2, 1'b1, 32'd100, 32'd7);
    for (int s = 0; s < N; s++) set_slot(s, 3, 1'b0, 0, 1'b0);
    for (int s = 0; s < 4; s++) set_slot(s, 2, 1'b1, s, 1'b1);
    step_check("R5");
    cmp("R5", 1'b1, 32'd128, 3);

    // R4: same group on last-value table, ordinals ignored
    for (int s = 0; s < 4; s++) slot_sel[s] = 1'b0;
    step_check("R4");
    cmp("R4", 1'b1, 32'd100, 3);

    // R7: wrap
    set_bank(1, 1'b1, 32'hFFFF_FFF0, 32'h0000_0010);
    set_slot(4, 1, 1'b1, 2, 1'b1);
    step_check("R7");
    cmp("R7", 1'b1, 32'h0000_0020, 4);

    // R6: invalid bank kills leader and followers
    set_bank(2, 1'b0, 32'd55, 32'd1);
    for (int s = 0; s < 4; s++) slot_sel[s] = 1'b1;
    step_check("R6");

    // R3: denied slot on a valid bank
    set_bank(2, 1'b1, 32'd55, 32'd1);
    slot_grant[1] = 1'b0;
    step_check("R3");

    // R8: mixed selects on one bank in one cycle
    set_bank(0, 1'b1, 32'd1000, 32'd3);
    for (int s = 0; s < N; s++) set_slot(s, 0, 1'b1, s, s[0]);
    step_check("R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      slot_bank   = N*BW'($urandom());
      slot_grant  = N'($urandom());
      slot_ord    = N*OW'($urandom());
      slot_sel    = N'($urandom());
      bank_valid  = NB'($urandom());
      for (int b = 0; b < NB; b++) begin
        bank_last[b*W +: W]   = $urandom();
        bank_stride[b*W +: W] = (i % 5 == 0) ? $urandom() : W'($urandom_range(0, 64));
      end
      step_check("");
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule